// File: doc/BRIEF.md
# Per-Chip-Select SPI Frame Engine

This block is the serial shift engine of an SPI master. Each chip select owns a 32-bit mode word. The word sets the clock idle level, the sampling phase, the bit order, the prescaler, the character length, the polarity of the select line, and three delays: select-to-first-edge, last-edge-to-release, and an idle gap between back-to-back characters. A host writes the mode words through a small write port. It then launches one character at a time with a start pulse, a chip-select index and the parallel transmit data.

While the engine is idle, `start` latches the mode word of the chosen chip select. It asserts that select line and waits the setup delay. It then shifts the character out on `mosi` while capturing `miso`, and returns `sck` to its idle level. When the character ends, `done` pulses for one cycle and `rx_data` holds the received bits. If `keep_sel` was high with the start, the select stays asserted and the engine waits in a held state. The next start in that state runs the gap delay and then the next character, on the same chip select. Otherwise the hold delay runs and the select line is released.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset every select pin is at its inactive level 1, `sck` is 0, and `done` and `busy` are 0. Every mode word resets to 0x0010_0008: active-low select, gap of 1, length field 0, all other fields 0.
- R2: One SCK half period is 2·(PM+1) system clocks, where PM is mode bits 27:24. When bit 28 is set the half period is 32·(PM+1) system clocks. A PM below 2 is used as 2.
- R3: `sck` sits at the latched idle level (mode bit 31) whenever no character is being shifted, and it is back at that level after the last edge of every character.
- R4: With mode bit 30 clear, each bit is on `mosi` before its leading SCK edge and is sampled on that edge. With bit 30 set, `mosi` changes on the leading edge and the sample is taken on the trailing edge.
- R5: With mode bit 29 set, the most significant bit of the character is sent first and the first received bit lands in the top position. With it clear, bit 0 goes first and the first received bit lands in bit 0.
- R6: Mode bits 19:16 give the length minus one. Values below 3 are used as 3, so lengths run from 4 to 16 bits. A character produces exactly 2·length SCK edges.
- R7: From the cycle the select asserts to the first SCK edge there are 2·S·H + H system clocks, where S is mode bits 15:12 and H is the half period. When S is 0 this is 1 + H.
- R8: From the last SCK edge to release of the select there are 2·D·H system clocks, where D is mode bits 11:8. When D is 0 this is 1 system clock.
- R9: With `keep_sel`, the select stays asserted after `done` and `busy` drops. A start in that state puts the first edge of the next character 2·G·H + H clocks after the start, where G is mode bits 7:3 (1 + H when G is 0).
- R10: Mode bit 20 set makes a select pin active low, and clear makes it active high. Only the pin of the latched chip select is ever driven active.
- R11: `done` is a single-cycle pulse per character, and with it `rx_data` holds the captured bits, with bits above the length reading zero.
- R12: While `busy` is high, `start` is ignored, and a mode-word write does not alter the character in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a mode word |
| cfg_idx | input | 2 | Chip select whose mode word is written |
| cfg_wdata | input | 32 | Mode word value |
| start | input | 1 | Launch one character |
| keep_sel | input | 1 | Keep the select asserted after this character |
| cs_idx | input | 2 | Chip select for a launch from idle |
| tx_data | input | 16 | Character to send, right-aligned |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| cs_pin | output | 4 | Select lines, one per chip select |
| rx_data | output | 16 | Last received character |
| done | output | 1 | Character-complete pulse |
| busy | output | 1 | A character or its delays are in progress |

## Verification
A wrong prescaler count or a wrong delay counter shows up at the pins within one character: the spacing between SCK edges, or the distance from a select change to the nearest edge, moves by whole half periods. The bench measures these spacings to the exact system clock. A broken edge counter or bit-position selection changes the number of SCK edges or the order of bits a device model sees, and it also corrupts `rx_data` at the next `done`. A stale latched mode, or a start accepted while busy, appears as a select on the wrong pin or as a second `done`.

// File: rtl/spi_fe_pkg.sv
// Shared types for the SPI frame engine: the decoded per-chip-select mode
// and the function that turns a raw 32-bit mode word into it.
// Assumes the field layout listed in the brief; unused word bits are dropped.
package spi_fe_pkg;

    localparam int MAX_LEN = 16;
    localparam logic [31:0] MODE_RESET_WORD = 32'h0010_0008;

    typedef struct packed {
        logic       cpol;      // clock idle level
        logic       cpha;      // sample on trailing edge when set
        logic       msb_first; // bit order
        logic       div16;     // extra divide-by-16
        logic [3:0] pm;        // prescale modulus, already clamped to >= 2
        logic       act_low;   // select polarity
        logic [3:0] lenm1;     // length minus one, already clamped to >= 3
        logic [3:0] setup;     // select-to-clock delay, SCK periods
        logic [3:0] hold;      // clock-to-release delay, SCK periods
        logic [4:0] gap;       // inter-character idle, SCK periods
    } mode_t;

    function automatic mode_t decode_mode(input logic [31:0] w);
        mode_t m;
        m.cpol      = w[31];
        m.cpha      = w[30];
        m.msb_first = w[29];
        m.div16     = w[28];
        m.pm        = (w[27:24] < 4'd2) ? 4'd2 : w[27:24];
        m.act_low   = w[20];
        m.lenm1     = (w[19:16] < 4'd3) ? 4'd3 : w[19:16];
        m.setup     = w[15:12];
        m.hold      = w[11:8];
        m.gap       = w[7:3];
        return m;
    endfunction

endpackage

// File: rtl/spi_mode_bank.sv
// Per-chip-select mode storage. Holds one decoded mode per chip select,
// written whole through a simple strobe; reads are combinational.
// Assumes NUM_CS is a power of two so every index value names a register.
module spi_mode_bank
    import spi_fe_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CSW-1:0]    cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic [CSW-1:0]    rd_idx,
    output mode_t             rd_mode,
    output logic [NUM_CS-1:0] act_low_all
);
    mode_t bank [NUM_CS];
    logic  unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[23:21], cfg_wdata[2:0]};

    for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
        // Load the decoded word for this chip select on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank[i] <= decode_mode(MODE_RESET_WORD);
            else if (cfg_we && cfg_idx == CSW'(i))
                bank[i] <= decode_mode(cfg_wdata);
        end
        assign act_low_all[i] = bank[i].act_low;
    end

    assign rd_mode = bank[rd_idx];

endmodule

// File: rtl/spi_sck_div.sv
// SCK prescaler. Emits a one-cycle tick every half SCK period while enabled;
// clr restarts the count so each timed phase begins on a fresh half period.
// Assumes pm and div16 stay constant while enabled.
module spi_sck_div #(
    parameter int PM_W = 4,
    localparam int CNT_W = PM_W + 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [PM_W-1:0] pm,
    input  logic            div16,
    output logic            tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] base;

    // Half period minus one: 2*(pm+1), times 16 when the extra stage is on.
    always_comb begin
        base    = (CNT_W'(pm) + CNT_W'(1)) << 1;
        half_m1 = (div16 ? (base << 4) : base) - CNT_W'(1);
    end

    // Free-running modulus counter, held at zero when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr)
            cnt <= '0;
        else if (cnt == half_m1)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    assign tick = en && (cnt == half_m1);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= half_m1));

endmodule

// File: rtl/spi_shift_core.sv
// Character sequencer and shifter. Runs setup, shift, hold, held and gap
// phases from the latched mode, drives SCK/MOSI and captures MISO.
// Assumes the divider tick is a single-cycle pulse that restarts on div_clr.
module spi_shift_core
    import spi_fe_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               keep,
    input  logic [CSW-1:0]     cs_idx,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               miso,
    input  mode_t              mode_in,
    input  logic               tick,
    output mode_t              mode_q,
    output logic               div_en,
    output logic               div_clr,
    output logic               sck,
    output logic               mosi,
    output logic               cs_act,
    output logic [CSW-1:0]     cs_sel,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               done,
    output logic               busy
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_HELD, ST_GAP
    } state_t;

    state_t             state, nxt;
    logic [MAX_LEN-1:0] tx_q, rx_q, rx_upd;
    logic [4:0]         e_cnt;
    logic [5:0]         dly;
    logic               keep_q, sck_q, mosi_q, done_q;
    logic [3:0]         k_now, drive_k;
    logic               lead, samp, last_edge, drive_en, dly_end;

    assign k_now     = e_cnt[4:1];
    assign lead      = ~e_cnt[0];
    assign samp      = lead ^ mode_q.cpha;
    assign last_edge = (e_cnt == {mode_q.lenm1, 1'b1});
    assign drive_en  = (lead == mode_q.cpha) && !last_edge;
    assign drive_k   = mode_q.cpha ? k_now : k_now + 4'd1;
    assign dly_end   = (dly == 6'd0) || (dly == 6'd1 && tick);

    // Position in the character of the k-th bit on the wire.
    function automatic logic [3:0] wire_pos(input logic [3:0] k, input mode_t m);
        return m.msb_first ? (m.lenm1 - k) : k;
    endfunction

    // Next phase of the character sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_SETUP;
            ST_SETUP: if (dly_end) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) nxt = keep_q ? ST_HELD : ST_HOLD;
            ST_HOLD:  if (dly_end) nxt = ST_IDLE;
            ST_HELD:  if (start) nxt = ST_GAP;
            ST_GAP:   if (dly_end) nxt = ST_SHIFT;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Received word including the bit sampled on the current edge.
    always_comb begin
        rx_upd = rx_q;
        if (samp) rx_upd[wire_pos(k_now, mode_q)] = miso;
    end

    // Sequencer, delay counter, shifter and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= decode_mode(MODE_RESET_WORD);
            tx_q    <= '0;
            rx_q    <= '0;
            rx_data <= '0;
            e_cnt   <= '0;
            dly     <= '0;
            keep_q  <= 1'b0;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b0;
            done_q  <= 1'b0;
            cs_sel  <= '0;
        end else begin
            state  <= nxt;
            done_q <= 1'b0;
            if (tick && dly != 6'd0 && state != ST_SHIFT) dly <= dly - 6'd1;
            if (state == ST_IDLE && start) begin
                mode_q <= mode_in;
                cs_sel <= cs_idx;
                tx_q   <= tx_data;
                keep_q <= keep;
                sck_q  <= mode_in.cpol;
                dly    <= {1'b0, mode_in.setup, 1'b0};
            end
            if (state == ST_HELD && start) begin
                tx_q   <= tx_data;
                keep_q <= keep;
                dly    <= {mode_q.gap, 1'b0};
            end
            if (state != ST_SHIFT && nxt == ST_SHIFT) begin
                e_cnt  <= '0;
                rx_q   <= '0;
                mosi_q <= tx_q[wire_pos(4'd0, mode_q)];
            end
            if (state == ST_SHIFT && tick) begin
                sck_q <= ~sck_q;
                e_cnt <= e_cnt + 5'd1;
                rx_q  <= rx_upd;
                if (drive_en) mosi_q <= tx_q[wire_pos(drive_k, mode_q)];
                if (last_edge) begin
                    done_q  <= 1'b1;
                    rx_data <= rx_upd;
                    dly     <= {1'b0, mode_q.hold, 1'b0};
                end
            end
        end
    end

    assign div_en  = (state != ST_IDLE) && (state != ST_HELD);
    assign div_clr = (nxt != state);
    assign busy    = div_en;
    assign cs_act  = (state != ST_IDLE);
    assign sck     = sck_q;
    assign mosi    = mosi_q;
    assign done    = done_q;

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> (sck_q == mode_q.cpol));
    assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (e_cnt <= {mode_q.lenm1, 1'b1}));
    assert_len_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.lenm1 >= 4'd3);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    assert_mode_latched_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

endmodule

// File: rtl/spi_frame_engine.sv
// Top of the SPI frame engine: mode bank, SCK prescaler and shift core,
// plus the per-pin select polarity. Assumes NUM_CS is a power of two.
module spi_frame_engine
    import spi_fe_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CSW-1:0]     cfg_idx,
    input  logic [31:0]        cfg_wdata,
    input  logic               start,
    input  logic               keep_sel,
    input  logic [CSW-1:0]     cs_idx,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [NUM_CS-1:0]  cs_pin,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               done,
    output logic               busy
);
    mode_t              sel_mode, run_mode;
    logic [NUM_CS-1:0]  act_low_all, asserted;
    logic               tick, div_en, div_clr, cs_act;
    logic [CSW-1:0]     cs_sel;

    spi_mode_bank #(.NUM_CS(NUM_CS)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rd_idx(cs_idx), .rd_mode(sel_mode),
        .act_low_all(act_low_all)
    );

    spi_sck_div #(.PM_W(4)) u_div (
        .clk(clk), .rst_n(rst_n), .en(div_en), .clr(div_clr),
        .pm(run_mode.pm), .div16(run_mode.div16), .tick(tick)
    );

    spi_shift_core #(.NUM_CS(NUM_CS)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .keep(keep_sel),
        .cs_idx(cs_idx), .tx_data(tx_data), .miso(miso), .mode_in(sel_mode),
        .tick(tick), .mode_q(run_mode), .div_en(div_en), .div_clr(div_clr),
        .sck(sck), .mosi(mosi), .cs_act(cs_act), .cs_sel(cs_sel),
        .rx_data(rx_data), .done(done), .busy(busy)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_pin
        assign asserted[i] = cs_act && (cs_sel == CSW'(i));
        // Active pin uses the latched polarity, idle pins their stored one.
        assign cs_pin[i] = asserted[i] ? ~run_mode.act_low : act_low_all[i];
    end

    assert_single_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(asserted));
    assert_idle_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> (sck == run_mode.cpol));

endmodule

// File: tb/spi_frame_engine_tb.sv
module spi_frame_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_idx = 0;
    logic [31:0] cfg_wdata = 0;
    logic        start = 0, keep_sel = 0;
    logic [1:0]  cs_idx = 0;
    logic [15:0] tx_data = 0;
    logic        inv = 0;
    logic        miso;
    logic        sck, mosi, done, busy;
    logic [3:0]  cs_pin;
    logic [15:0] rx_data;

    int checks = 0, errors = 0, cyc = 0;
    // results of the last transfer
    int edges, first_e, second_e, last_e, t_start, cs_off, nb;
    logic [31:0] bits_v;
    logic [15:0] got_rx;
    logic        got_done;

    assign miso = mosi ^ inv;

    spi_frame_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .start(start), .keep_sel(keep_sel),
        .cs_idx(cs_idx), .tx_data(tx_data), .miso(miso), .sck(sck),
        .mosi(mosi), .cs_pin(cs_pin), .rx_data(rx_data), .done(done),
        .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit cpol, input bit cpha, input bit msb,
            input bit d16, input int pm, input bit pol, input int lenm1,
            input int su, input int ho, input int gap);
        return {cpol, cpha, msb, d16, 4'(pm), 3'b000, pol, 4'(lenm1),
                4'(su), 4'(ho), 5'(gap), 3'b000};
    endfunction

    function automatic int half_of(input int pm, input bit d16);
        int p = (pm < 2) ? 2 : pm;
        return 2 * (p + 1) * (d16 ? 16 : 1);
    endfunction

    function automatic int dly_of(input int n, input int half);
        return (n == 0) ? 1 : 2 * n * half;
    endfunction

    task automatic wr_mode(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Launch one character and observe SCK/MOSI/select like a device would.
    task automatic xfer(input int idx, input logic [15:0] tx, input bit keep,
                        input bit cpol, input bit cpha, input bit pol);
        logic prev;
        edges = 0; nb = 0; bits_v = '0; first_e = -1; second_e = -1;
        last_e = -1; cs_off = -1; got_done = 0; got_rx = '0;
        @(negedge clk);
        cs_idx = 2'(idx); tx_data = tx; keep_sel = keep; start = 1;
        @(negedge clk);
        start = 0; t_start = cyc; prev = cpol;
        for (int n = 0; n < 40000; n++) begin
            if (sck !== prev) begin
                edges++;
                if (first_e < 0) first_e = cyc;
                else if (second_e < 0) second_e = cyc;
                last_e = cyc;
                if ((prev == cpol) != cpha) begin
                    bits_v[nb] = mosi;
                    nb++;
                end
                prev = sck;
            end
            if (done) begin
                got_done = 1; got_rx = rx_data;
                break;
            end
            @(negedge clk);
        end
        if (!keep) begin
            for (int n = 0; n < 40000; n++) begin
                if (cs_pin[idx] == pol) begin cs_off = cyc; break; end
                @(negedge clk);
            end
        end
    endtask

    // Common checks on the last character against the requirements.
    task automatic check_char(input string tag, input logic [15:0] tx, input int len,
            input bit msb, input int half, input int su_cyc, input int ho_cyc);
        logic [15:0] mask, exp_rx;
        bit order_ok;
        mask = 16'((32'd1 << len) - 1);
        exp_rx = inv ? (~tx & mask) : (tx & mask);
        chk(got_done, {tag, " R11 done seen"}, int'(got_done), 1);
        chk(edges == 2 * len, {tag, " R6 edge count"}, edges, 2 * len);
        chk(second_e - first_e == half, {tag, " R2 half period"}, second_e - first_e, half);
        chk(got_rx == exp_rx, {tag, " R11 rx_data"}, int'(got_rx), int'(exp_rx));
        order_ok = (nb == len);
        for (int k = 0; k < len; k++)
            if (bits_v[k] !== (msb ? tx[len-1-k] : tx[k])) order_ok = 0;
        chk(order_ok, {tag, " R4 R5 wire bit order"}, int'(bits_v), int'(tx & mask));
        if (su_cyc >= 0)
            chk(first_e - t_start == su_cyc, {tag, " R7 setup"}, first_e - t_start, su_cyc);
        if (ho_cyc >= 0)
            chk(cs_off - last_e == ho_cyc, {tag, " R8 hold"}, cs_off - last_e, ho_cyc);
    endtask

    task automatic t_reset;
        chk(cs_pin == 4'hF, "R1 select pins idle", int'(cs_pin), 15);
        chk(sck == 1'b0, "R1 sck idle", int'(sck), 0);
        chk(!done && !busy, "R1 done/busy low", int'({done, busy}), 0);
    endtask

    task automatic t_default;
        // reset mode: length 4, LSB first, PM clamped to 2, no delays
        xfer(0, 16'h00A6, 0, 0, 0, 1);
        check_char("default", 16'h00A6, 4, 0, 6, 1 + 6, 1);
        chk(busy == 0 && cs_pin == 4'hF, "R1 idle after", int'(cs_pin), 15);
    endtask

    task automatic t_shape;
        int h = half_of(3, 0);
        wr_mode(1, mk(1, 1, 1, 0, 3, 1, 11, 2, 1, 1));
        xfer(1, 16'h0B5A, 0, 1, 1, 1);
        check_char("shape", 16'h0B5A, 12, 1, h, 2 * 2 * h + h, 2 * 1 * h);
        chk(sck == 1'b1, "R3 sck back to high idle", int'(sck), 1);
    endtask

    task automatic t_phases;
        for (int m = 0; m < 4; m++) begin
            wr_mode(2, mk(m[1], m[0], 1, 0, 2, 1, 7, 0, 0, 1));
            xfer(2, 16'h0096, 0, m[1], m[0], 1);
            check_char("phase", 16'h0096, 8, 1, 6, 7, 1);
            chk(sck == m[1], "R3 idle level per mode", int'(sck), m[1]);
        end
    endtask

    task automatic t_div16;
        // PM field 1 is clamped to 2, then the divide-by-16 stage applies
        wr_mode(2, mk(0, 0, 0, 1, 1, 1, 3, 0, 0, 1));
        xfer(2, 16'h0005, 0, 0, 0, 1);
        check_char("div16", 16'h0005, 4, 0, 96, 1 + 96, 1);
    endtask

    task automatic t_invert;
        inv = 1;
        wr_mode(0, mk(0, 0, 1, 0, 2, 1, 9, 0, 0, 1));
        xfer(0, 16'h0263, 0, 0, 0, 1);
        check_char("invert", 16'h0263, 10, 1, 6, 7, 1);
        inv = 0;
    endtask

    task automatic t_gap;
        int h = 6;
        wr_mode(3, mk(0, 0, 1, 0, 2, 1, 7, 0, 0, 3));
        xfer(3, 16'h00C3, 1, 0, 0, 1);
        check_char("gap first", 16'h00C3, 8, 1, h, 7, -1);
        repeat (40) @(negedge clk);
        chk(cs_pin[3] == 0 && !busy, "R9 select held while waiting", int'(cs_pin[3]), 0);
        xfer(3, 16'h003C, 0, 0, 0, 1);
        check_char("gap second", 16'h003C, 8, 1, h, 2 * 3 * h + h, 1);
        wr_mode(3, mk(0, 0, 1, 0, 2, 1, 7, 0, 0, 0));
        xfer(3, 16'h0011, 1, 0, 0, 1);
        xfer(3, 16'h0022, 0, 0, 0, 1);
        check_char("gap zero", 16'h0022, 8, 1, h, 1 + h, 1);
    endtask

    task automatic t_polarity;
        bit seen_active = 0, others_ok = 1;
        wr_mode(1, mk(0, 0, 1, 0, 2, 0, 3, 0, 0, 1));
        @(negedge clk);
        chk(cs_pin[1] == 0, "R10 active-high pin idles low", int'(cs_pin[1]), 0);
        @(negedge clk);
        cs_idx = 1; tx_data = 16'h0009; keep_sel = 0; start = 1;
        @(negedge clk);
        start = 0;
        for (int n = 0; n < 200; n++) begin
            if (cs_pin[1]) seen_active = 1;
            if (cs_pin[0] != 1 || cs_pin[2] != 1 || cs_pin[3] != 1) others_ok = 0;
            @(negedge clk);
        end
        chk(seen_active, "R10 active-high pin driven high", int'(seen_active), 1);
        chk(others_ok, "R10 other pins stay inactive", int'(others_ok), 1);
        chk(cs_pin[1] == 0, "R10 released low", int'(cs_pin[1]), 0);
    endtask

    task automatic t_busy_ignore;
        int dones = 0; bit other_ok = 1; logic [15:0] last_rx = '0;
        wr_mode(0, mk(0, 0, 0, 0, 2, 1, 3, 0, 0, 1));
        @(negedge clk);
        cs_idx = 0; tx_data = 16'h0007; keep_sel = 0; start = 1;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        cs_idx = 2; tx_data = 16'h0008; start = 1;
        @(negedge clk);
        start = 0;
        for (int n = 0; n < 300; n++) begin
            if (done) begin dones++; last_rx = rx_data; end
            if (cs_pin[2] == 0) other_ok = 0;
            @(negedge clk);
        end
        chk(dones == 1, "R12 start while busy ignored", dones, 1);
        chk(other_ok, "R12 no select on ignored index", int'(other_ok), 1);
        chk(last_rx == 16'h0007, "R12 character unchanged", int'(last_rx), 7);
    endtask

    task automatic t_latch;
        int e = 0; logic prev;
        wr_mode(1, mk(0, 0, 1, 0, 3, 1, 11, 0, 0, 1));
        @(negedge clk);
        cs_idx = 1; tx_data = 16'h0ABC; keep_sel = 0; start = 1;
        @(negedge clk);
        start = 0; prev = 0;
        repeat (30) @(negedge clk);
        cfg_we = 1; cfg_idx = 1; cfg_wdata = mk(1, 0, 0, 0, 2, 1, 15, 0, 0, 1);
        @(negedge clk);
        cfg_we = 0;
        for (int n = 0; n < 600; n++) begin
            if (sck !== prev) begin e++; prev = sck; end
            if (done) break;
            @(negedge clk);
        end
        chk(e == 22, "R12 mode write mid-character ignored (edges after write)", e, 22);
        chk(rx_data == 16'h0ABC, "R12 rx intact", int'(rx_data), 16'h0ABC);
    endtask

    task automatic t_lengths;
        wr_mode(0, mk(0, 0, 1, 0, 2, 1, 1, 0, 0, 1));
        xfer(0, 16'h00FE, 0, 0, 0, 1);
        check_char("len clamp", 16'h00FE, 4, 1, 6, 7, 1);
        wr_mode(0, mk(0, 0, 1, 0, 2, 1, 15, 0, 0, 1));
        xfer(0, 16'hA5C3, 0, 0, 0, 1);
        check_char("len 16", 16'hA5C3, 16, 1, 6, 7, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_default();
        t_shape();
        t_phases();
        t_div16();
        t_invert();
        t_gap();
        t_polarity();
        t_busy_ignore();
        t_latch();
        t_lengths();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule